// File: doc/BRIEF.md
# Direction-Strapped Serial Word Link

This block is one end of a narrow serial link that carries 12-bit parallel words over a single data wire plus a clock wire. A direction strap is read once, right after reset, and fixes the role for the rest of the run. As transmitter it takes a word from its parallel input whenever the strobe rises. It wraps the word in a short frame whose leading marker bit tells the far end where a word begins. It shifts the frame out on the data wire, changing the data only on falling edges of a forwarded bit clock that it generates from the system clock.

As receiver it watches the incoming bit clock and samples the data wire on each of its rising edges. It hunts for the marker bit, collects the word and checks the closing bit. Only when the frame is well formed does it place the word on its parallel output and give a one-cycle word clock pulse. The parallel output enable is high only in receiver role, so one shared pad set can serve either direction. Strobe edges are never back-pressured. One word can wait while another is on the wire, and a third is dropped and flagged.

Top module: `dir_serial_link`

## Requirements
- R1: On the first clock after reset is released, `role_sel` is sampled: 1 selects transmitter, 0 selects receiver. Later changes of `role_sel` have no effect until the next reset.
- R2: In transmitter role, `par_in` is captured in the cycle where `strobe` is first seen high after being low.
- R3: In transmitter role `ser_clk_o` toggles every `HALF_DIV` system clocks. In receiver role and during reset it stays 0.
- R4: A frame is 14 bits: a start bit of 1, then the 12 data bits MSB first, then a stop bit of 0. `ser_dat_o` changes only on the cycle where `ser_clk_o` falls, so every bit is stable at the next rising edge.
- R5: When no word is pending, `ser_dat_o` is held at 0.
- R6: Each captured word produces exactly one frame, in capture order. A word captured while a frame is shifting waits in a one-entry holding register, and frames may follow back to back.
- R7: A strobe rise while the holding register is full and not being emptied drops that word and sets `tx_overrun`. The flag stays set until reset.
- R8: In receiver role `ser_dat_i` is sampled at each rising edge of `ser_clk_i`. A 1 starts a frame. After 12 data bits, a stop bit of 0 updates `par_out` and raises `rx_word_clk` for exactly one cycle, in the cycle after the clock edge that saw the rising bit clock.
- R9: A stop bit of 1 discards the frame: `par_out` keeps its previous value, `rx_word_clk` stays low, and `rx_frame_err` pulses for one cycle.
- R10: `par_oe` is 1 only in receiver role, and 0 during reset and in transmitter role. In receiver role `strobe` and `par_in` have no effect: the serial outputs stay 0 and `par_out` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| role_sel | input | 1 | Direction strap, 1 transmitter, 0 receiver |
| strobe | input | 1 | Word strobe, rising edge captures `par_in` |
| par_in | input | 12 | Parallel word into the transmitter |
| par_out | output | 12 | Last good word from the receiver |
| par_oe | output | 1 | Drive enable for the shared parallel pads |
| ser_clk_o | output | 1 | Forwarded bit clock |
| ser_dat_o | output | 1 | Serial data out |
| ser_clk_i | input | 1 | Received bit clock |
| ser_dat_i | input | 1 | Serial data in |
| rx_word_clk | output | 1 | One-cycle pulse on each good word |
| rx_frame_err | output | 1 | One-cycle pulse on a bad stop bit |
| tx_overrun | output | 1 | Sticky dropped-word flag |

## Verification
The bench decodes the transmitted line itself. It goes after words of all ones and all zeros, where a design that dropped the start marker or sent LSB first would produce a wrong or unframed word. A burst of three strobes a few cycles apart tests the holding register. A design without it loses the second word; one that overwrote the held word reports a third frame, or sets no overrun flag. On the receive side, back-to-back frames and a frame with a bad stop bit are injected. A receiver that skipped the stop check would present that corrupted word, and one that re-armed late would miss the start bit that follows a stop bit directly. Flipping the strap after reset and pulsing the strobe in receiver role expose a role latch that is not held, or a transmitter that is not gated.

// File: rtl/link_pkg.sv
package link_pkg;
  typedef enum logic {
    ROLE_RX = 1'b0,
    ROLE_TX = 1'b1
  } role_e;
endpackage

// File: rtl/link_role_cfg.sv
module link_role_cfg
  import link_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  role_sel,
  output role_e role,
  output logic  cfg_done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      role     <= ROLE_RX;
      cfg_done <= 1'b0;
    end else if (!cfg_done) begin
      role     <= role_sel ? ROLE_TX : ROLE_RX;
      cfg_done <= 1'b1;
    end
  end

  // R1: once latched, the role never moves
  p_role_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> (cfg_done && $stable(role)));
endmodule

// File: rtl/link_bitclk.sv
module link_bitclk #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic bclk,
  output logic fall_ev
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (!en) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      bclk <= ~bclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // the next edge takes the forwarded clock low
  assign fall_ev = en && (cnt == LAST) && bclk;
endmodule

// File: rtl/link_tx.sv
module link_tx #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         fall_ev,
  input  logic         strobe,
  input  logic [W-1:0] par_in,
  output logic         ser_dat,
  output logic         overrun
);
  localparam int FRAME = W + 2;
  localparam int LW    = $clog2(FRAME + 1);
  localparam logic [LW-1:0] FRAME_LEN = LW'(FRAME);
  localparam logic [LW-1:0] ONE       = LW'(1);

  logic             strb_q;
  logic [W-1:0]     hold_w;
  logic             hold_v;
  logic [FRAME-1:0] shreg;
  logic [LW-1:0]    left;
  logic             cap, take;

  assign cap  = en && strobe && !strb_q;
  assign take = fall_ev && hold_v && (left <= ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q  <= 1'b0;
      hold_w  <= '0;
      hold_v  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      strb_q <= en && strobe;
      if (cap && (!hold_v || take)) begin
        hold_w <= par_in;
        hold_v <= 1'b1;
      end else if (take) begin
        hold_v <= 1'b0;
      end
      if (cap && hold_v && !take) overrun <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
    end else if (fall_ev) begin
      if (left > ONE) begin
        shreg <= {shreg[FRAME-2:0], 1'b0};
        left  <= left - ONE;
      end else if (hold_v) begin
        shreg <= {1'b1, hold_w, 1'b0};
        left  <= FRAME_LEN;
      end else begin
        shreg <= '0;
        left  <= '0;
      end
    end
  end

  assign ser_dat = shreg[FRAME-1];

  // R7: overrun is sticky
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R7: a capture into a full, unreleased holding register raises the flag
  p_drop_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && hold_v && !take) |=> overrun);
  // R5: no line activity while nothing is queued or shifting
  p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (left == '0) |-> !ser_dat);
endmodule

// File: rtl/link_rx.sv
module link_rx #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         ser_clk_i,
  input  logic         ser_dat_i,
  output logic [W-1:0] par_out,
  output logic         word_clk,
  output logic         frame_err
);
  localparam int CW = $clog2(W + 2);
  localparam logic [CW-1:0] LAST_DATA = CW'(W);
  localparam logic [CW-1:0] ONE       = CW'(1);

  logic          ck_q;
  logic          rise;
  logic [CW-1:0] cnt;
  logic [W-1:0]  dreg;

  assign rise = en && ser_clk_i && !ck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q      <= 1'b0;
      cnt       <= '0;
      dreg      <= '0;
      par_out   <= '0;
      word_clk  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      ck_q      <= en && ser_clk_i;
      word_clk  <= 1'b0;
      frame_err <= 1'b0;
      if (rise) begin
        if (cnt == '0) begin
          if (ser_dat_i) cnt <= ONE;
        end else if (cnt <= LAST_DATA) begin
          dreg <= {dreg[W-2:0], ser_dat_i};
          cnt  <= cnt + ONE;
        end else begin
          cnt <= '0;
          if (!ser_dat_i) begin
            par_out  <= dreg;
            word_clk <= 1'b1;
          end else begin
            frame_err <= 1'b1;
          end
        end
      end
    end
  end

  // R8: word clock is a single-cycle pulse
  p_word_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    word_clk |=> !word_clk);
  // R9: a frame is either accepted or rejected, never both
  p_accept_xor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_clk && frame_err));
  // R9: a rejected frame leaves the parallel word alone
  p_keep_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $stable(par_out));
endmodule

// File: rtl/dir_serial_link.sv
module dir_serial_link
  import link_pkg::*;
#(
  parameter int W        = 12,
  parameter int HALF_DIV = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         role_sel,
  input  logic         strobe,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] par_out,
  output logic         par_oe,
  output logic         ser_clk_o,
  output logic         ser_dat_o,
  input  logic         ser_clk_i,
  input  logic         ser_dat_i,
  output logic         rx_word_clk,
  output logic         rx_frame_err,
  output logic         tx_overrun
);
  role_e role;
  logic  cfg_done;
  logic  tx_en, rx_en;
  logic  fall_ev;

  link_role_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .role_sel (role_sel),
    .role     (role),
    .cfg_done (cfg_done)
  );

  assign tx_en  = cfg_done && (role == ROLE_TX);
  assign rx_en  = cfg_done && (role == ROLE_RX);
  assign par_oe = rx_en;

  link_bitclk #(.HALF_DIV(HALF_DIV)) u_bclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (tx_en),
    .bclk    (ser_clk_o),
    .fall_ev (fall_ev)
  );

  link_tx #(.W(W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (tx_en),
    .fall_ev (fall_ev),
    .strobe  (strobe),
    .par_in  (par_in),
    .ser_dat (ser_dat_o),
    .overrun (tx_overrun)
  );

  link_rx #(.W(W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (rx_en),
    .ser_clk_i (ser_clk_i),
    .ser_dat_i (ser_dat_i),
    .par_out   (par_out),
    .word_clk  (rx_word_clk),
    .frame_err (rx_frame_err)
  );

  // R4: serial data moves only with a falling forwarded clock
  p_src_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(ser_dat_o) |-> $fell(ser_clk_o));
  // R10: with the pads driven, the transmit side is silent
  p_oe_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> (!ser_clk_o && !ser_dat_o && !tx_overrun));
  // R10: the receiver reports nothing while in transmit role
  p_tx_no_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_oe) |-> (!rx_word_clk && !rx_frame_err));
endmodule

// File: tb/tb_dir_serial_link.sv
`timescale 1ns/1ps
module tb_dir_serial_link;
  localparam int W  = 12;
  localparam int HD = 2;

  logic         clk = 1'b0;
  logic         rst_n, role_sel, strobe, ser_clk_i, ser_dat_i;
  logic [W-1:0] par_in, par_out;
  logic         par_oe, ser_clk_o, ser_dat_o, rx_word_clk, rx_frame_err, tx_overrun;

  always #2.5 clk = ~clk;

  dir_serial_link #(.W(W), .HALF_DIV(HD)) dut (
    .clk(clk), .rst_n(rst_n), .role_sel(role_sel), .strobe(strobe),
    .par_in(par_in), .par_out(par_out), .par_oe(par_oe),
    .ser_clk_o(ser_clk_o), .ser_dat_o(ser_dat_o),
    .ser_clk_i(ser_clk_i), .ser_dat_i(ser_dat_i),
    .rx_word_clk(rx_word_clk), .rx_frame_err(rx_frame_err),
    .tx_overrun(tx_overrun)
  );

  int checks = 0, errors = 0;
  logic [W-1:0] txq[$];
  logic [W-1:0] rxq[$];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // transmit-side monitor: decodes the line, compares against the scoreboard
  bit           mon_on = 0;
  logic         prev_ck, prev_dat;
  int           cyc, last_tog, st, frames;
  bit           seen_tog;
  logic [W-1:0] sh;

  always @(negedge clk) begin
    if (!mon_on) begin
      prev_ck = 0; prev_dat = 0; cyc = 0; seen_tog = 0; st = 0;
    end else begin
      cyc++;
      if (ser_clk_o != prev_ck) begin
        if (seen_tog) chk((cyc - last_tog) == HD, "R3", "half period", cyc - last_tog, HD);
        last_tog = cyc; seen_tog = 1;
      end
      if (ser_dat_o != prev_dat)
        chk(prev_ck && !ser_clk_o, "R4", "data moved off a falling edge", ser_clk_o, 0);
      if (!prev_ck && ser_clk_o) begin
        if (st == 0) begin
          if (ser_dat_o) st = 1;
        end else if (st <= W) begin
          sh = {sh[W-2:0], ser_dat_o};
          st++;
        end else begin
          st = 0;
          chk(ser_dat_o == 1'b0, "R4", "stop bit", ser_dat_o, 0);
          frames++;
          if (txq.size() == 0) chk(0, "R6", "unexpected frame", sh, 0);
          else begin
            logic [W-1:0] e;
            e = txq.pop_front();
            chk(sh == e, "R6", "frame word", sh, e);
          end
        end
      end
      prev_ck = ser_clk_o; prev_dat = ser_dat_o;
    end
  end

  // receive-side monitor
  always @(negedge clk) begin
    if (rst_n && rx_word_clk) begin
      if (rxq.size() == 0) chk(0, "R8", "unexpected word clock", par_out, 0);
      else begin
        logic [W-1:0] e;
        e = rxq.pop_front();
        chk(par_out == e, "R8", "received word", par_out, e);
      end
    end
  end

  int ferr_cnt = 0;
  always @(negedge clk) if (rst_n && rx_frame_err) ferr_cnt++;

  task automatic do_reset(input bit role);
    rst_n = 0; role_sel = role; strobe = 0; par_in = '0;
    ser_clk_i = 0; ser_dat_i = 0;
    repeat (4) @(negedge clk);
    chk(!par_oe && !ser_clk_o && !ser_dat_o && !rx_word_clk && !rx_frame_err && !tx_overrun
        && par_out == '0, "R10", "reset state", {par_oe, ser_clk_o, ser_dat_o, tx_overrun}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic tx_send(input logic [W-1:0] w, input bit drop);
    @(negedge clk);
    par_in = w; strobe = 1;
    if (!drop) txq.push_back(w);
    @(negedge clk);
    @(negedge clk); strobe = 0;
    par_in = ~w;
    @(negedge clk);
  endtask

  task automatic rx_frame(input logic [W-1:0] w, input bit good);
    logic [W+1:0] f;
    f = {1'b1, w, good ? 1'b0 : 1'b1};
    if (good) rxq.push_back(w);
    for (int i = W + 1; i >= 0; i--) begin
      @(negedge clk); ser_dat_i = f[i]; ser_clk_i = 0;
      @(negedge clk);
      @(negedge clk); ser_clk_i = 1;
      @(negedge clk);
      if (i == 0) begin
        chk(rx_word_clk == good, "R8", "word clock timing", rx_word_clk, good);
        chk(rx_frame_err == !good, "R9", "frame error pulse", rx_frame_err, !good);
      end
    end
    @(negedge clk); ser_clk_i = 0; ser_dat_i = 0;
  endtask

  task automatic rx_idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ser_dat_i = 0; ser_clk_i = 0;
      @(negedge clk);
      @(negedge clk); ser_clk_i = 1;
      @(negedge clk);
    end
  endtask

  initial begin
    frames = 0;
    // ---------------- transmitter role ----------------
    do_reset(1'b1);
    chk(par_oe == 1'b0, "R1", "transmit role pads released", par_oe, 0);
    mon_on = 1;
    role_sel = 0;  // R1: late strap change must be ignored
    tx_send(12'hA5C, 0); repeat (70) @(negedge clk);   // R2 capture
    tx_send(12'hFFF, 0); repeat (70) @(negedge clk);
    tx_send(12'h000, 0); repeat (70) @(negedge clk);
    tx_send(12'h801, 0); repeat (70) @(negedge clk);
    chk(txq.size() == 0, "R2", "all single words framed", txq.size(), 0);
    chk(par_oe == 1'b0, "R1", "role held after strap flip", par_oe, 0);
    chk(tx_overrun == 1'b0, "R7", "no overrun on spaced words", tx_overrun, 0);
    begin
      int bad = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (ser_dat_o) bad++;
      end
      chk(bad == 0, "R5", "idle line low", bad, 0);
    end
    tx_send(12'h123, 0);
    tx_send(12'h456, 0);
    tx_send(12'h789, 1);
    chk(tx_overrun == 1'b1, "R7", "overrun on third strobe", tx_overrun, 1);
    repeat (150) @(negedge clk);
    chk(txq.size() == 0, "R6", "queued word delivered", txq.size(), 0);
    chk(frames == 6, "R6", "frame count", frames, 6);
    chk(tx_overrun == 1'b1, "R7", "overrun sticky", tx_overrun, 1);
    mon_on = 0;

    // ---------------- receiver role ----------------
    do_reset(1'b0);
    role_sel = 1;
    @(negedge clk);
    chk(par_oe == 1'b1, "R1", "receive role pads driven", par_oe, 1);
    rx_idle(3);
    rx_frame(12'h3C5, 1);
    rx_frame(12'hFFF, 1);                 // back to back
    rx_idle(2);
    rx_frame(12'h000, 1);
    rx_frame(12'hABC, 0);                 // bad stop
    repeat (4) @(negedge clk);
    chk(par_out == 12'h000, "R9", "word kept after bad frame", par_out, 12'h000);
    rx_frame(12'h001, 1);
    begin
      int bad = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk); par_in = 12'hF0F; strobe = 1;
        @(negedge clk); @(negedge clk); strobe = 0;
        @(negedge clk);
      end
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (ser_clk_o || ser_dat_o) bad++;
      end
      chk(bad == 0, "R10", "strobe ignored in receive role", bad, 0);
      chk(par_out == 12'h001, "R10", "par_out untouched by strobe", par_out, 12'h001);
    end
    chk(rxq.size() == 0, "R8", "all good words presented", rxq.size(), 0);
    chk(ferr_cnt == 1, "R9", "frame error pulse count", ferr_cnt, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule